// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a reduced-latency DRAM. After reset it drives the command bus through the bring-up sequence the memory needs before it accepts normal traffic. First it holds the bus idle (NOP) for a programmable settling interval, counted only while power-good is high. Next comes a train of mode-register writes: several throw-away writes with the address forced to zero, then the real one that carries the mode value. A guard gap follows. Then it sends one auto-refresh to every bank, and a run of idle cycles long enough to cover both the required NOP window and the row-cycle time of the last refreshed bank.

When the sequence completes, the block raises a done flag. The surrounding controller uses that flag to hand the bus over to normal traffic. Loss of power-good or an active reset restarts the whole sequence from the settling wait, with done low. All intervals are parameters in clock cycles. The settling interval defaults to the clock frequency times a duration in microseconds.

Top module: `dram_pwrup_seq`

## Requirements
- R1: While rst_ni is low, the outputs are cs_n_o=1, cmd_o=NOP, addr_o=0, bank_o=0 and done_o=0. The reset is asynchronous.
- R2: Command encoding on cmd_o is 2'b00 NOP, 2'b01 mode-register write and 2'b10 auto-refresh. cs_n_o is 1 exactly when cmd_o is NOP.
- R3: The first mode-register write appears only after STABLE_CYC consecutive cycles in which pwr_good_i is sampled high, all carrying NOP. While pwr_good_i is low, only NOP is driven.
- R4: The settling wait is followed at once by N_DUMMY back-to-back mode-register writes with addr_o=0 and bank_o=0.
- R5: In the cycle directly after the last of those writes, one more mode-register write carries addr_o=MODE_VAL.
- R6: Exactly MRSC_CYC NOP cycles separate the valid mode-register write from the first auto-refresh.
- R7: The auto-refreshes go to banks 0 to N_BANK-1 in ascending order on consecutive cycles, with addr_o=0.
- R8: After the last auto-refresh, exactly max(NOP_WIN, RC_CYC) NOP cycles pass with done_o=0. In the next cycle done_o goes high.
- R9: Once high, done_o stays high with NOP on the bus for as long as pwr_good_i stays high.
- R10: A low pwr_good_i at any point of the sequence gives NOP and done_o=0 in the following cycle. The full sequence then restarts from R3 once pwr_good_i is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Supplies and clock stable |
| cs_n_o | output | 1 | Chip select, active low |
| cmd_o | output | 2 | Command code (NOP, mode write, refresh) |
| addr_o | output | ADDR_W | Address bus |
| bank_o | output | $clog2(N_BANK) | Bank select |
| done_o | output | 1 | Initialization complete |

## Verification
The full command stream is compared, cycle by cycle, against a position-indexed model. This tells apart errors in the length of each phase (settling, dummy train, guard, refresh burst, tail) and errors in the address or bank carried by each phase. A near-exhaustive sweep then drops power-good at every position of the sequence and after done. Each drop must give an idle bus at once and a complete restart, which separates a correct restart from state that leaks out of any single phase. Holding power-good low after reset shows that the settling count does not run without it. A mid-run reset checks the asynchronous clear.

// File: rtl/dram_pwrup_pkg.sv
package dram_pwrup_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_MRS = 2'b01,
    CMD_REF = 2'b10
  } cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_DUMMY,
    ST_MODE,
    ST_GUARD,
    ST_REF,
    ST_TAIL,
    ST_DONE
  } phase_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_d_o,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_comb begin
    cnt_d_o = cnt_q;
    if (load_i)                   cnt_d_o = load_val_i;
    else if (dec_i && cnt_q != '0) cnt_d_o = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= W'(RST_VAL);
    else         cnt_q <= cnt_d_o;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // the phase machine must never ask to count below zero
  p_no_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> (cnt_q != '0));

endmodule

// File: rtl/dram_seq_cmd_drv.sv
module dram_seq_cmd_drv
  import dram_pwrup_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_d_i,
  input  logic [BANK_W-1:0] bank_d_i,
  input  logic [ADDR_W-1:0] mode_i,
  output logic              cs_n_o,
  output logic [1:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              done_o
);

  cmd_e              cmd_d;
  logic [ADDR_W-1:0] addr_d;
  logic [BANK_W-1:0] bank_d;
  logic              done_d;

  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    bank_d = '0;
    done_d = 1'b0;
    case (phase_d_i)
      ST_DUMMY: cmd_d = CMD_MRS;
      ST_MODE: begin
        cmd_d  = CMD_MRS;
        addr_d = mode_i;
      end
      ST_REF: begin
        cmd_d  = CMD_REF;
        bank_d = bank_d_i;
      end
      ST_DONE: done_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_o <= 1'b1;
      cmd_o  <= CMD_NOP;
      addr_o <= '0;
      bank_o <= '0;
      done_o <= 1'b0;
    end else begin
      cs_n_o <= (cmd_d == CMD_NOP);
      cmd_o  <= cmd_d;
      addr_o <= addr_d;
      bank_o <= bank_d;
      done_o <= done_d;
    end
  end

endmodule

// File: rtl/dram_pwrup_seq.sv
module dram_pwrup_seq
  import dram_pwrup_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 200,
  parameter int unsigned STABLE_US  = 200,
  parameter int unsigned STABLE_CYC = CLK_MHZ * STABLE_US,
  parameter int unsigned N_DUMMY    = 2,
  parameter int unsigned MRSC_CYC   = 6,
  parameter int unsigned RC_CYC     = 8,
  parameter int unsigned NOP_WIN    = 1024,
  parameter int unsigned N_BANK     = 8,
  parameter int unsigned ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] MODE_VAL = '0,
  localparam int unsigned BANK_W    = $clog2(N_BANK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  output logic              cs_n_o,
  output logic [1:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              done_o
);

  localparam int unsigned TAIL_CYC = max_u(NOP_WIN, RC_CYC);
  localparam int unsigned CNT_MAX  = max_u(max_u(STABLE_CYC, TAIL_CYC),
                                           max_u(max_u(N_DUMMY, MRSC_CYC), N_BANK));
  localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);
  localparam int unsigned RCC_W    = $clog2(RC_CYC + 1);

  phase_e             phase_q, phase_d;
  logic               ld, dec, cnt_zero;
  logic [CNT_W-1:0]   ld_val, cnt_q, cnt_d;
  logic [BANK_W-1:0]  bank_d;

  // phase sequencing; every phase length sits in the shared timer
  always_comb begin
    phase_d = phase_q;
    ld      = 1'b0;
    ld_val  = '0;
    dec     = 1'b0;
    if (!pwr_good_i) begin
      phase_d = ST_WAIT;
      ld      = 1'b1;
      ld_val  = CNT_W'(STABLE_CYC);
    end else begin
      case (phase_q)
        ST_WAIT:
          if (cnt_zero) begin
            phase_d = ST_DUMMY;
            ld      = 1'b1;
            ld_val  = CNT_W'(N_DUMMY - 1);
          end else dec = 1'b1;
        ST_DUMMY:
          if (cnt_zero) begin
            phase_d = ST_MODE;
            ld      = 1'b1;
          end else dec = 1'b1;
        ST_MODE: begin
          phase_d = ST_GUARD;
          ld      = 1'b1;
          ld_val  = CNT_W'(MRSC_CYC - 1);
        end
        ST_GUARD:
          if (cnt_zero) begin
            phase_d = ST_REF;
            ld      = 1'b1;
            ld_val  = CNT_W'(N_BANK - 1);
          end else dec = 1'b1;
        ST_REF:
          if (cnt_zero) begin
            phase_d = ST_TAIL;
            ld      = 1'b1;
            ld_val  = CNT_W'(TAIL_CYC - 1);
          end else dec = 1'b1;
        ST_TAIL:
          if (cnt_zero) phase_d = ST_DONE;
          else          dec = 1'b1;
        ST_DONE: phase_d = ST_DONE;
        default: begin
          phase_d = ST_WAIT;
          ld      = 1'b1;
          ld_val  = CNT_W'(STABLE_CYC);
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= ST_WAIT;
    else         phase_q <= phase_d;
  end

  dram_seq_timer #(
    .W      (CNT_W),
    .RST_VAL(STABLE_CYC)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ld),
    .load_val_i(ld_val),
    .dec_i     (dec),
    .cnt_o     (cnt_q),
    .cnt_d_o   (cnt_d),
    .zero_o    (cnt_zero)
  );

  // refresh bank rises as the timer falls
  assign bank_d = BANK_W'(N_BANK - 1) - cnt_d[BANK_W-1:0];

  dram_seq_cmd_drv #(
    .ADDR_W(ADDR_W),
    .BANK_W(BANK_W)
  ) u_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phase_d_i(phase_d),
    .bank_d_i (bank_d),
    .mode_i   (MODE_VAL),
    .cs_n_o   (cs_n_o),
    .cmd_o    (cmd_o),
    .addr_o   (addr_o),
    .bank_o   (bank_o),
    .done_o   (done_o)
  );

  // per-bank cycles since last refresh on the bus, for the row-cycle check
  logic [N_BANK-1:0] rc_met;
  for (genvar b = 0; b < N_BANK; b++) begin : g_rc
    logic [RCC_W-1:0] rc_cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rc_cnt_q <= RCC_W'(RC_CYC);
      else if (cmd_o == CMD_REF && bank_o == BANK_W'(b)) rc_cnt_q <= '0;
      else if (rc_cnt_q < RCC_W'(RC_CYC)) rc_cnt_q <= rc_cnt_q + 1'b1;
    end
    assign rc_met[b] = (rc_cnt_q >= RCC_W'(RC_CYC));

    p_rc_before_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_o) |-> rc_met[b]);
  end

  p_dummy_addr_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_DUMMY) |-> (cmd_o == CMD_MRS && addr_o == '0));

  p_guard_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_GUARD) |-> (cmd_o == CMD_NOP && cs_n_o));

  p_ref_ascending_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF && $past(cmd_o) == CMD_REF) |-> (bank_o == $past(bank_o) + 1'b1));

  p_done_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pwr_good_i) |=> done_o);

  p_pg_loss_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> (!done_o && cmd_o == CMD_NOP));

endmodule

// File: tb/dram_pwrup_seq_tb.sv
module dram_pwrup_seq_tb;

  localparam int unsigned ST     = 6;
  localparam int unsigned ND     = 2;
  localparam int unsigned MRSC   = 3;
  localparam int unsigned RC     = 5;
  localparam int unsigned NW     = 12;
  localparam int unsigned NB     = 8;
  localparam int unsigned AW     = 12;
  localparam int unsigned BW     = $clog2(NB);
  localparam logic [AW-1:0] MODE = 12'hA5C;
  localparam int unsigned TAIL   = (NW > RC) ? NW : RC;
  localparam int unsigned TOTAL  = ST + ND + 1 + MRSC + NB + TAIL;
  localparam int unsigned VW     = 1 + 2 + AW + BW + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pg = 1'b0;
  logic          cs_n, done;
  logic [1:0]    cmd;
  logic [AW-1:0] addr;
  logic [BW-1:0] bank;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            finished = 1'b0;

  always #10 clk = ~clk;

  dram_pwrup_seq #(
    .CLK_MHZ(50), .STABLE_US(1), .STABLE_CYC(ST), .N_DUMMY(ND),
    .MRSC_CYC(MRSC), .RC_CYC(RC), .NOP_WIN(NW), .N_BANK(NB),
    .ADDR_W(AW), .MODE_VAL(MODE)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg),
    .cs_n_o(cs_n), .cmd_o(cmd), .addr_o(addr), .bank_o(bank), .done_o(done)
  );

  function automatic logic [VW-1:0] pack(logic c, logic [1:0] k, logic [AW-1:0] a,
                                         logic [BW-1:0] b, logic d);
    return {c, k, a, b, d};
  endfunction

  // NOP 00 / MRS 01 / REF 10, cs_n high only on NOP (R2)
  function automatic logic [VW-1:0] exp_at(int p);
    if (p < ST)                    return pack(1'b1, 2'b00, '0, '0, 1'b0);
    if (p < ST + ND)               return pack(1'b0, 2'b01, '0, '0, 1'b0);
    if (p == ST + ND)              return pack(1'b0, 2'b01, MODE, '0, 1'b0);
    if (p < ST + ND + 1 + MRSC)    return pack(1'b1, 2'b00, '0, '0, 1'b0);
    if (p < ST + ND + 1 + MRSC + NB)
      return pack(1'b0, 2'b10, '0, BW'(p - (ST + ND + 1 + MRSC)), 1'b0);
    if (p < TOTAL)                 return pack(1'b1, 2'b00, '0, '0, 1'b0);
    return pack(1'b1, 2'b00, '0, '0, 1'b1);
  endfunction

  function automatic string req_at(int p);
    if (p < ST)                    return "R3";
    if (p < ST + ND)               return "R4";
    if (p == ST + ND)              return "R5";
    if (p < ST + ND + 1 + MRSC)    return "R6";
    if (p < ST + ND + 1 + MRSC + NB) return "R7";
    if (p < TOTAL)                 return "R8";
    return "R9";
  endfunction

  task automatic chk(string req, logic [VW-1:0] exp);
    logic [VW-1:0] act;
    act = pack(cs_n, cmd, addr, bank, done);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t act=%h exp=%h", req, $time, act, exp);
    end
  endtask

  // pg already high before the next edge; check positions 0..len-1
  task automatic run_from_start(int len);
    for (int p = 0; p < len; p++) begin
      @(negedge clk);
      chk(req_at(p), exp_at(p));
    end
  endtask

  task automatic drop_pg_and_restart();
    pg = 1'b0;
    @(negedge clk);
    chk("R10", pack(1'b1, 2'b00, '0, '0, 1'b0));
    pg = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", pack(1'b1, 2'b00, '0, '0, 1'b0));
    rst_n = 1'b1;
    // no settling progress without power-good (R3)
    for (int i = 0; i < 2 * ST; i++) begin
      @(negedge clk);
      chk("R3", pack(1'b1, 2'b00, '0, '0, 1'b0));
    end
    pg = 1'b1;
    run_from_start(TOTAL + 10);
    // drop power-good at every position, then a full rerun (R10)
    for (int k = 0; k <= TOTAL + 2; k++) begin
      drop_pg_and_restart();
      run_from_start(k);
    end
    drop_pg_and_restart();
    run_from_start(TOTAL + 4);
    // asynchronous reset mid-sequence (R1)
    drop_pg_and_restart();
    run_from_start(ST + ND + 3);
    #3 rst_n = 1'b0;
    #2 chk("R1", pack(1'b1, 2'b00, '0, '0, 1'b0));
    @(negedge clk);
    chk("R1", pack(1'b1, 2'b00, '0, '0, 1'b0));
    rst_n = 1'b1;
    run_from_start(TOTAL + 2);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule